// File: doc/BRIEF.md
# Serial Register Command Engine

This block is the device-side handler for register access commands that arrive over a byte-wide serial target stream. The host lowers chip select and sends 32-bit words most significant byte first. The first word is a command header. The engine checks the header's parity and decodes it: direction, address step mode, memory map, start address and register count. It then carries out the register accesses on an internal register file. It sends back a reply stream that runs one word behind the input. Reply word 0 is zero. Reply word 1 is the echoed header. The words after that are the echoed write data or the read data.

The register file holds `NUM_MAPS` maps of `MAP_DEPTH` 32-bit registers. A header that fails parity sets a sticky bad-header flag, performs no access and gets an all-zero reply. Raising chip select abandons any command in progress.

The controller is a four-state machine:
- `ST_HDR` waits for the header. A good control header moves it to `ST_WR` or `ST_RD`. A bad or non-control header moves it to `ST_DRAIN`.
- `ST_WR` and `ST_RD` perform one access per completed word. After the last access they move to `ST_DRAIN`.
- `ST_DRAIN` ignores every further word.
- Chip select high returns the machine to `ST_HDR` from any state.

Top module: `regcmd_engine`

## Requirements
- R1: After reset, `out_vld` and `hdr_bad` are 0 and every register in every map reads as zero.
- R2: Reply timing and framing.
  - Each byte accepted while `cs_n` is low (`in_vld`=1) produces `out_vld`=1 with its reply byte in the next cycle.
  - Reply word 0 of a transaction is 0.
  - Reply word 1 is the header exactly as received, except that bit 30 is forced to 0.
  - Words are sent most significant byte first.
- R3: A header with bit 29 = 1 is a write. Its next N = LEN+1 words are written to successive registers. They are echoed as reply words 2..N+1. The word after them is not applied.
- R4: A header with bit 29 = 0 is a read. Reply words 2..N+1 carry the contents of N successive registers. All host data after the header is ignored.
- R5: Header bit 28 = 1 keeps every access of the command at the start address. Bit 28 = 0 steps the address by one after each access.
- R6: The header fields are:
  - bits 7..1: LEN, the register count minus one, so 0 gives one access and 127 gives 128;
  - bits 27..24: map selector;
  - bits 23..8: start address.
- R7: An access with map selector >= `NUM_MAPS`, or address >= `MAP_DEPTH`, is unimplemented. A write to it changes no register, and a read of it returns 0.
- R8: Bit 0 makes the header's population count odd.
  - A header with even parity performs no access, and all its reply words are 0.
  - It sets `hdr_bad`, which stays set until reset.
- R9: A header with bit 31 = 1 is not a control command. It performs no access and its reply is all zero. Header bit 30 sent by the host has no effect on the command.
- R10: Deasserting `cs_n` discards a partly received word. Accesses already completed are kept. The next transaction starts at header wait.
- R11: Words received after a command's last access are ignored and answered with zero.
- R12: `in_vld` while `cs_n` is high is ignored and produces no `out_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high ends the transaction |
| in_vld | input | 1 | One input byte is present this cycle |
| in_byte | input | 8 | Input byte from the host |
| out_vld | output | 1 | Reply byte is present this cycle |
| out_byte | output | 8 | Reply byte to the host |
| hdr_bad | output | 1 | Sticky flag: a header with a parity error was received |

## Verification
- **Reply byte timing.** A reply byte is registered on the edge that accepts its input byte. The bench drives each byte at a falling edge and reads `out_byte` and `out_vld` at the next falling edge, where the reply for that slot is due.
- **Back-to-back data.** The reply word for slot k is prepared on the edge that completes input word k-1. The bench inserts random gaps of zero or one cycle between bytes, so that back-to-back bytes exercise this shortest path.
- **Write visibility.** A write lands on the edge that completes its data word. The bench makes writes visible only through later read commands, and updates its model word by word in the same order.
- **Sticky flag.** `hdr_bad` is sampled after chip select has been raised.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    localparam int CMD_W  = 32;
    localparam int BYTE_W = 8;
    localparam int MMS_W  = 4;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 7;

    typedef enum logic [1:0] {
        ST_HDR   = 2'd0,
        ST_WR    = 2'd1,
        ST_RD    = 2'd2,
        ST_DRAIN = 2'd3
    } cmd_state_e;

    // field positions are fixed by the host protocol
    typedef struct packed {
        logic              dnc;
        logic              hbad;
        logic              wnr;
        logic              aid;
        logic [MMS_W-1:0]  mms;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              par;
    } cmd_hdr_t;

endpackage

// File: rtl/regcmd_word_rx.sv
module regcmd_word_rx
    import regcmd_pkg::*;
#(
    parameter int BYTES = CMD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              accepted,
    output logic              first_byte,
    output logic              word_done,
    output logic [CMD_W-1:0]  word
);

    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int ACC_W = CMD_W - BYTE_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

    logic [IDX_W-1:0] idx_q;
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (cs_n) begin
            idx_q <= '0;
        end else if (in_vld) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            acc_q <= {acc_q[ACC_W-BYTE_W-1:0], in_byte};
        end
    end

    always_comb begin
        accepted   = in_vld && !cs_n;
        first_byte = accepted && (idx_q == '0);
        word_done  = accepted && (idx_q == LAST);
        word       = {acc_q, in_byte};
    end

    // R10
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (idx_q == '0));

endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile
    import regcmd_pkg::*;
#(
    parameter int NUM_MAPS  = 2,
    parameter int MAP_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MMS_W-1:0]  mms,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  wdata,
    output logic [CMD_W-1:0]  rdata
);

    localparam int ENTRIES = NUM_MAPS * MAP_DEPTH;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [CMD_W-1:0] ent_q [ENTRIES];

    always_comb begin
        hit = (int'(mms) < NUM_MAPS) && (int'(addr) < MAP_DEPTH);
        idx = IDX_W'(int'(mms) * MAP_DEPTH + int'(addr));
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [CMD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && hit && (idx == IDX_W'(g)))
                q <= wdata;
        end
        assign ent_q[g] = q;
    end

    assign rdata = hit ? ent_q[idx] : '0;

endmodule

// File: rtl/regcmd_fsm.sv
module regcmd_fsm
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              word_done,
    input  logic [CMD_W-1:0]  word,
    input  logic [CMD_W-1:0]  rd_data,
    output logic              acc_wr,
    output logic [MMS_W-1:0]  acc_mms,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [CMD_W-1:0]  acc_wdata,
    output logic [CMD_W-1:0]  nxt_word,
    output logic              hdr_bad
);

    cmd_state_e        st_q, st_d;
    cmd_hdr_t          hd;
    logic              hdr_good;
    logic [LEN_W-1:0]  cnt_q, len_q;
    logic [MMS_W-1:0]  mms_q;
    logic [ADDR_W-1:0] addr_q;
    logic              aid_q;
    logic [CMD_W-1:0]  nxt_q;
    logic              bad_q;
    logic              last_acc;

    always_comb begin
        hd       = cmd_hdr_t'(word);
        hdr_good = ^word;
        last_acc = (cnt_q == len_q);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HDR: begin
                if (word_done) begin
                    if (!hdr_good || hd.dnc)
                        st_d = ST_DRAIN;
                    else if (hd.wnr)
                        st_d = ST_WR;
                    else
                        st_d = ST_RD;
                end
            end
            ST_WR, ST_RD: begin
                if (word_done && last_acc)
                    st_d = ST_DRAIN;
            end
            ST_DRAIN: st_d = ST_DRAIN;
            default:  st_d = ST_HDR;
        endcase
        if (cs_n)
            st_d = ST_HDR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_HDR;
        else
            st_q <= st_d;
    end

    // command context and reply word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            mms_q  <= '0;
            addr_q <= '0;
            aid_q  <= 1'b0;
            nxt_q  <= '0;
            bad_q  <= 1'b0;
        end else if (cs_n) begin
            nxt_q <= '0;
        end else if (word_done) begin
            unique case (st_q)
                ST_HDR: begin
                    cnt_q  <= '0;
                    len_q  <= hd.len;
                    mms_q  <= hd.mms;
                    addr_q <= hd.addr;
                    aid_q  <= hd.aid;
                    if (!hdr_good) begin
                        bad_q <= 1'b1;
                        nxt_q <= '0;
                    end else if (hd.dnc) begin
                        nxt_q <= '0;
                    end else begin
                        nxt_q <= {word[CMD_W-1], 1'b0, word[CMD_W-3:0]};
                    end
                end
                ST_WR, ST_RD: begin
                    nxt_q <= (st_q == ST_WR) ? word : rd_data;
                    cnt_q <= cnt_q + 1'b1;
                    if (!aid_q)
                        addr_q <= addr_q + 1'b1;
                end
                ST_DRAIN: nxt_q <= '0;
                default:  nxt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc_wr    = word_done && (st_q == ST_WR);
        acc_mms   = mms_q;
        acc_addr  = addr_q;
        acc_wdata = word;
        nxt_word  = nxt_q;
        hdr_bad   = bad_q;
    end

    // R8
    bad_hdr_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && word_done && (st_q == ST_HDR) && !(^word)) |=> ((st_q == ST_DRAIN) && hdr_bad));

    // R8
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_bad |=> hdr_bad);

    // R5
    aid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && aid_q) |=> $stable(addr_q));

    // R3
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |-> (cnt_q <= len_q));

    // R4
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && word_done && (st_q == ST_RD)) |=> (nxt_q == $past(rd_data)));

endmodule

// File: rtl/regcmd_word_tx.sv
module regcmd_word_tx
    import regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accepted,
    input  logic              first_byte,
    input  logic [CMD_W-1:0]  nxt_word,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte
);

    localparam int SH_W = CMD_W - BYTE_W;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_byte <= '0;
            sh_q     <= '0;
        end else begin
            out_vld <= accepted;
            if (accepted) begin
                if (first_byte) begin
                    out_byte <= nxt_word[CMD_W-1 -: BYTE_W];
                    sh_q     <= nxt_word[SH_W-1:0];
                end else begin
                    out_byte <= sh_q[SH_W-1 -: BYTE_W];
                    sh_q     <= {sh_q[SH_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                end
            end
        end
    end

    // R12
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> out_vld);

    // R12
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accepted |=> !out_vld);

endmodule

// File: rtl/regcmd_engine.sv
module regcmd_engine
    import regcmd_pkg::*;
#(
    parameter int NUM_MAPS  = 2,
    parameter int MAP_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       in_vld,
    input  logic [7:0] in_byte,
    output logic       out_vld,
    output logic [7:0] out_byte,
    output logic       hdr_bad
);

    logic              accepted, first_byte, word_done;
    logic [CMD_W-1:0]  word, rd_data, nxt_word, acc_wdata;
    logic              acc_wr;
    logic [MMS_W-1:0]  acc_mms;
    logic [ADDR_W-1:0] acc_addr;

    regcmd_word_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .in_vld     (in_vld),
        .in_byte    (in_byte),
        .accepted   (accepted),
        .first_byte (first_byte),
        .word_done  (word_done),
        .word       (word)
    );

    regcmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .word_done (word_done),
        .word      (word),
        .rd_data   (rd_data),
        .acc_wr    (acc_wr),
        .acc_mms   (acc_mms),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .nxt_word  (nxt_word),
        .hdr_bad   (hdr_bad)
    );

    regcmd_regfile #(
        .NUM_MAPS  (NUM_MAPS),
        .MAP_DEPTH (MAP_DEPTH)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc_wr),
        .mms   (acc_mms),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .rdata (rd_data)
    );

    regcmd_word_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .accepted   (accepted),
        .first_byte (first_byte),
        .nxt_word   (nxt_word),
        .out_vld    (out_vld),
        .out_byte   (out_byte)
    );

endmodule

// File: tb/regcmd_engine_tb_top.sv
module regcmd_engine_tb_top;

    localparam int CLK_NS = 10;
    localparam int NMAP   = 2;
    localparam int DEPTH  = 16;
    localparam int WDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = '0;
    logic       out_vld;
    logic [7:0] out_byte;
    logic       hdr_bad;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  bad_model = 1'b0;
    logic [31:0] model [NMAP*DEPTH];

    always #(CLK_NS/2) clk = ~clk;

    regcmd_engine #(.NUM_MAPS(NMAP), .MAP_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .in_vld(in_vld), .in_byte(in_byte),
        .out_vld(out_vld), .out_byte(out_byte), .hdr_bad(hdr_bad)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input int mms, input int a);
        if (mms < NMAP && a < DEPTH) return model[mms*DEPTH + a];
        return 32'h0;
    endfunction

    task automatic mwrite(input int mms, input int a, input logic [31:0] d);
        if (mms < NMAP && a < DEPTH) model[mms*DEPTH + a] = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; in_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NMAP*DEPTH; i++) model[i] = 32'h0;
        bad_model = 1'b0;
        @(negedge clk);
    endtask

    // caller is at a falling edge; returns at a falling edge
    task automatic send_byte(input logic [7:0] b, output logic [7:0] r, output logic v);
        in_vld = 1'b1; in_byte = b;
        @(negedge clk);
        r = out_byte; v = out_vld;
        in_vld = 1'b0;
        repeat ($urandom % 2) @(negedge clk);
    endtask

    task automatic xfer_word(input logic [31:0] w, output logic [31:0] r, output bit allv);
        logic [7:0] rb;
        logic v;
        allv = 1'b1;
        for (int k = 3; k >= 0; k--) begin
            send_byte(w[k*8 +: 8], rb, v);
            r[k*8 +: 8] = rb;
            if (!v) allv = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
    endtask

    task automatic cs_end();
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_hdr(input bit dnc, input bit h30, input bit wnr, input bit aid,
                                           input logic [3:0] mms, input logic [15:0] addr,
                                           input logic [6:0] len, input bit bad_par);
        logic [31:0] h;
        h = {dnc, h30, wnr, aid, mms, addr, len, 1'b0};
        h[0] = ~(^h[31:1]);
        if (bad_par) h[0] = ~h[0];
        return h;
    endfunction

    task automatic do_cmd(input bit wnr, input bit aid, input logic [3:0] mms, input logic [15:0] addr,
                          input logic [6:0] len, input bit bad_par, input bit dnc, input bit h30,
                          input int extra, input string req);
        logic [31:0] h, wd, prev_wd, r, exp;
        bit valid, allv, vall;
        int n, total;
        h = mk_hdr(dnc, h30, wnr, aid, mms, addr, len, bad_par);
        valid = !bad_par && !dnc;
        if (bad_par) bad_model = 1'b1;
        n = int'(len) + 1;
        total = n + 2 + extra;
        prev_wd = 32'h0;
        vall = 1'b1;
        cs_begin();
        for (int j = 0; j < total; j++) begin
            wd = (j == 0) ? h : $urandom;
            if (j == 0) exp = 32'h0;
            else if (!valid) exp = 32'h0;
            else if (j == 1) exp = {h[31], 1'b0, h[29:0]};
            else if (j <= n + 1)
                exp = wnr ? prev_wd : mread(int'(mms), int'(aid ? addr : addr + 16'(j - 2)));
            else exp = 32'h0;
            // write data word j lands during this word (R3); last word not applied
            if (valid && wnr && j >= 1 && j <= n)
                mwrite(int'(mms), int'(aid ? addr : addr + 16'(j - 1)), wd);
            xfer_word(wd, r, allv);
            if (!allv) vall = 1'b0;
            chk($sformatf("%s word%0d", (j == 1) ? "R2" : req, j), r, exp);
            prev_wd = wd;
        end
        cs_end();
        chk("R12 out_vld per byte", {31'h0, vall}, 32'h1);
        chk("R8 hdr_bad", {31'h0, hdr_bad}, {31'h0, bad_model});
    endtask

    initial begin
        logic [31:0] r, d0;
        logic [7:0]  rb;
        logic        v;
        bit          allv;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk("R1 out_vld", {31'h0, out_vld}, 32'h0);
        chk("R1 hdr_bad", {31'h0, hdr_bad}, 32'h0);
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd15, 1'b0, 1'b0, 1'b0, 0, "R1");
        do_cmd(1'b0, 1'b0, 4'd1, 16'd0, 7'd15, 1'b0, 1'b0, 1'b0, 0, "R1");

        // R6 single register, R3 burst, R4 readback
        do_cmd(1'b1, 1'b0, 4'd0, 16'd3, 7'd0, 1'b0, 1'b0, 1'b0, 0, "R6");
        do_cmd(1'b0, 1'b0, 4'd0, 16'd2, 7'd2, 1'b0, 1'b0, 1'b0, 0, "R6");
        do_cmd(1'b1, 1'b0, 4'd1, 16'd5, 7'd7, 1'b0, 1'b0, 1'b0, 0, "R3");
        do_cmd(1'b0, 1'b0, 4'd1, 16'd4, 7'd9, 1'b0, 1'b0, 1'b0, 0, "R4");

        // R5 address hold
        do_cmd(1'b1, 1'b1, 4'd0, 16'd7, 7'd3, 1'b0, 1'b0, 1'b0, 0, "R5");
        do_cmd(1'b0, 1'b1, 4'd0, 16'd7, 7'd2, 1'b0, 1'b0, 1'b0, 0, "R5");
        do_cmd(1'b0, 1'b0, 4'd0, 16'd6, 7'd2, 1'b0, 1'b0, 1'b0, 0, "R5");

        // R7 unimplemented map and addresses
        do_cmd(1'b1, 1'b0, 4'd3, 16'd0, 7'd3, 1'b0, 1'b0, 1'b0, 0, "R7");
        do_cmd(1'b1, 1'b0, 4'd0, 16'd14, 7'd4, 1'b0, 1'b0, 1'b0, 0, "R7");
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd19, 1'b0, 1'b0, 1'b0, 0, "R7");
        do_cmd(1'b0, 1'b0, 4'd3, 16'd0, 7'd3, 1'b0, 1'b0, 1'b0, 0, "R7");

        // R6 maximum length, both step modes
        do_cmd(1'b1, 1'b1, 4'd0, 16'd9, 7'd127, 1'b0, 1'b0, 1'b0, 0, "R6");
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd127, 1'b0, 1'b0, 1'b0, 0, "R6");

        // R9 non-control header, host bit 30
        do_cmd(1'b1, 1'b0, 4'd0, 16'd1, 7'd1, 1'b0, 1'b1, 1'b0, 0, "R9");
        do_cmd(1'b1, 1'b0, 4'd0, 16'd1, 7'd1, 1'b0, 1'b0, 1'b1, 0, "R9");
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd3, 1'b0, 1'b0, 1'b1, 0, "R9");

        // R11 trailing words
        do_cmd(1'b0, 1'b0, 4'd1, 16'd5, 7'd1, 1'b0, 1'b0, 1'b0, 3, "R11");
        do_cmd(1'b1, 1'b0, 4'd1, 16'd0, 7'd0, 1'b0, 1'b0, 1'b0, 2, "R11");

        // R10 abort mid-command
        cs_begin();
        xfer_word(mk_hdr(1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'd10, 7'd3, 1'b0), r, allv);
        d0 = $urandom;
        xfer_word(d0, r, allv);
        mwrite(0, 10, d0);
        send_byte(8'hA5, rb, v);
        send_byte(8'h5A, rb, v);
        cs_end();
        do_cmd(1'b0, 1'b0, 4'd0, 16'd10, 7'd1, 1'b0, 1'b0, 1'b0, 0, "R10");

        // R12 bytes with chip select high
        @(negedge clk);
        in_vld = 1'b1; in_byte = 8'hFF;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R12 ignored byte", {31'h0, out_vld}, 32'h0);
        do_cmd(1'b0, 1'b0, 4'd0, 16'd10, 7'd0, 1'b0, 1'b0, 1'b0, 0, "R12");

        // random mix
        for (int i = 0; i < 60; i++) begin
            do_cmd(1'($urandom), 1'($urandom), 4'($urandom % 3), 16'($urandom % 20),
                   7'($urandom % 8), 1'b0, 1'b0, 1'($urandom), int'($urandom % 2), "R3");
        end
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd15, 1'b0, 1'b0, 1'b0, 0, "R4");
        do_cmd(1'b0, 1'b0, 4'd1, 16'd0, 7'd15, 1'b0, 1'b0, 1'b0, 0, "R4");

        // R8 parity error: no access, sticky flag
        do_cmd(1'b1, 1'b0, 4'd0, 16'd0, 7'd3, 1'b1, 1'b0, 1'b0, 0, "R8");
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd3, 1'b0, 1'b0, 1'b0, 0, "R8");
        do_cmd(1'b0, 1'b1, 4'd1, 16'd2, 7'd2, 1'b1, 1'b0, 1'b0, 0, "R8");

        // R1 reset clears flag and registers
        do_reset();
        chk("R1 hdr_bad after reset", {31'h0, hdr_bad}, 32'h0);
        do_cmd(1'b0, 1'b0, 4'd0, 16'd0, 7'd15, 1'b0, 1'b0, 1'b0, 0, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule